// File: doc/BRIEF.md
# 128-bit Lane Permute Unit

This unit is one stage of a wide-register datapath. It takes two 128-bit source operands, called `src_a` (the first source register) and `src_b` (the second source register), and builds a 128-bit result by moving whole 32-bit, 16-bit or 8-bit fields between lanes. It does no arithmetic. Each operation is a fixed but irregular cross-lane shuffle: even-word packing, lower-half interleaving at a selectable element width, upper-word interleaving, halfword broadcast within each doubleword, doubleword copies, and a three-word rotation that keeps the top word where it is.

The issue logic supplies an opcode, an element-width code and three flags. Two flags mark a source as the hard-wired zero register, and one marks the destination as that register. A source marked as zero reads as all zeros. A zero destination, or the reserved opcode, turns the operation into a no-op. In a no-op no write is signalled and the result register keeps its value. The result is registered, and `out_valid` and `out_we` come with it one cycle after `in_valid`.

Top module: `lane_permute_unit`

## Requirements
- R1: After reset `out_valid`, `out_we` and `out_data` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_we` is high in that cycle only if the destination is not the zero register and the opcode is not 7.
- R3: Opcode 0 (pack even words) gives {a.w2, a.w0, b.w2, b.w0}, written from word 3 down to word 0.
- R4: Opcode 1 (lower interleave) takes bits 63:0 of both sources and alternates elements from element 0 upward. In each pair the `src_b` element sits in the lower position and the `src_a` element above it. The element width comes from `gran`: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R5: Opcode 2 (upper word interleave) gives {a.w3, b.w3, a.w2, b.w2}.
- R6: Opcode 3 (halfword broadcast) copies b.h0 into halfwords 0 to 3 and b.h4 into halfwords 4 to 7.
- R7: Opcode 4 (copy lower doublewords) puts b[63:0] in result bits 63:0 and a[63:0] in bits 127:64.
- R8: Opcode 5 (copy upper doublewords) puts a[127:64] in result bits 63:0 and b[127:64] in bits 127:64.
- R9: Opcode 6 (rotate three words) gives {b.w3, b.w0, b.w2, b.w1}, so word 3 is unchanged.
- R10: When `src_a_zero` or `src_b_zero` is set, that source takes part in the operation as all zeros, whatever its data.
- R11: With `dst_zero` set, `out_we` stays low and `out_data` keeps its previous value.
- R12: Opcode 7 is reserved. It behaves as a no-op: `out_we` stays low and `out_data` is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| op | input | 3 | Operation code (0 to 6, 7 reserved) |
| gran | input | 2 | Interleave element width code |
| src_a_zero | input | 1 | First source is the zero register |
| src_b_zero | input | 1 | Second source is the zero register |
| dst_zero | input | 1 | Destination is the zero register |
| src_a | input | 128 | First source operand |
| src_b | input | 128 | Second source operand |
| out_valid | output | 1 | Result cycle marker |
| out_we | output | 1 | Destination write enable |
| out_data | output | 128 | Permuted result |

## Verification
The bench uses operands whose every byte is unique, so a field taken from the wrong lane or the wrong source shows up as a wrong byte value. It goes after the swap of pair order in the interleaves (the result would show `src_a` bytes in the low slots), the take-over of word 3 in the rotation (the top word would change), and the broadcast reading halfword 4 for the upper half (all eight halfwords would come out equal). It also checks that zero-register sources are forced to zero, that a zero destination and the reserved opcode leave the result held with no write, and that the spare width code falls back to word interleave. A design that got the no-op wrong would assert a write or lose the previous result.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

  localparam int unsigned QUAD_W = 128;
  localparam int unsigned DBL_W  = QUAD_W / 2;
  localparam int unsigned WRD_W  = 32;
  localparam int unsigned HLF_W  = 16;
  localparam int unsigned BYT_W  = 8;

  typedef enum logic [2:0] {
    OP_PACK_EVEN = 3'd0,
    OP_ILV_LO    = 3'd1,
    OP_ILV_HI_W  = 3'd2,
    OP_BCAST_H   = 3'd3,
    OP_COPY_LO   = 3'd4,
    OP_COPY_HI   = 3'd5,
    OP_ROT3      = 3'd6,
    OP_RESERVED  = 3'd7
  } perm_op_e;

  typedef enum logic [1:0] {
    GR_BYTE = 2'd0,
    GR_HALF = 2'd1,
    GR_WORD = 2'd2,
    GR_WIDE = 2'd3
  } gran_e;

  // Alternate elements of width ew from lo (even slots) and hi (odd slots).
  function automatic logic [QUAD_W-1:0] f_interleave(input logic [DBL_W-1:0] hi_src,
                                                      input logic [DBL_W-1:0] lo_src,
                                                      input int unsigned ew);
    logic [QUAD_W-1:0] r;
    for (int k = 0; k < QUAD_W; k++) begin
      int unsigned pair;
      int unsigned pos;
      pair = k / (2 * ew);
      pos  = k % (2 * ew);
      if (pos < ew) r[k] = lo_src[pair*ew + pos];
      else          r[k] = hi_src[pair*ew + pos - ew];
    end
    return r;
  endfunction

  function automatic logic [WRD_W-1:0] f_word(input logic [QUAD_W-1:0] v, input int unsigned idx);
    return v[idx*WRD_W +: WRD_W];
  endfunction

  function automatic logic [QUAD_W-1:0] f_pack_even(input logic [QUAD_W-1:0] a,
                                                     input logic [QUAD_W-1:0] b);
    return {f_word(a, 2), f_word(a, 0), f_word(b, 2), f_word(b, 0)};
  endfunction

  function automatic logic [QUAD_W-1:0] f_bcast_half(input logic [QUAD_W-1:0] b);
    logic [HLF_W-1:0] lo_h;
    logic [HLF_W-1:0] hi_h;
    lo_h = b[HLF_W-1:0];
    hi_h = b[DBL_W +: HLF_W];
    return {{(DBL_W/HLF_W){hi_h}}, {(DBL_W/HLF_W){lo_h}}};
  endfunction

  function automatic logic [QUAD_W-1:0] f_rot3(input logic [QUAD_W-1:0] b);
    return {f_word(b, 3), f_word(b, 0), f_word(b, 2), f_word(b, 1)};
  endfunction

endpackage

// File: rtl/lperm_src_gate.sv
module lperm_src_gate #(
  parameter int unsigned WIDTH = lperm_pkg::QUAD_W
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             is_zero_reg,
  output logic [WIDTH-1:0] gated
);
  assign gated = is_zero_reg ? '0 : raw;
endmodule

// File: rtl/lperm_interleave.sv
module lperm_interleave #(
  parameter int unsigned ELEM_W = 8
) (
  input  logic [lperm_pkg::DBL_W-1:0]  hi_src,
  input  logic [lperm_pkg::DBL_W-1:0]  lo_src,
  output logic [lperm_pkg::QUAD_W-1:0] mixed
);
  always_comb mixed = lperm_pkg::f_interleave(hi_src, lo_src, ELEM_W);
endmodule

// File: rtl/lperm_shuffle.sv
module lperm_shuffle
  import lperm_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [1:0]        gran,
  input  logic [QUAD_W-1:0] opa,
  input  logic [QUAD_W-1:0] opb,
  output logic [QUAD_W-1:0] result,
  output logic              op_writes
);
  localparam int unsigned N_GRAN = 3;
  localparam int unsigned GRAN_W [N_GRAN] = '{BYT_W, HLF_W, WRD_W};

  logic [QUAD_W-1:0] ilv_lo [N_GRAN];
  logic [QUAD_W-1:0] ilv_hi_w;
  logic [QUAD_W-1:0] ilv_sel;

  for (genvar g = 0; g < N_GRAN; g++) begin : g_ilv
    lperm_interleave #(.ELEM_W(GRAN_W[g])) u_ilv (
      .hi_src (opa[DBL_W-1:0]),
      .lo_src (opb[DBL_W-1:0]),
      .mixed  (ilv_lo[g])
    );
  end

  lperm_interleave #(.ELEM_W(WRD_W)) u_ilv_hi (
    .hi_src (opa[QUAD_W-1:DBL_W]),
    .lo_src (opb[QUAD_W-1:DBL_W]),
    .mixed  (ilv_hi_w)
  );

  always_comb begin
    case (gran_e'(gran))
      GR_BYTE: ilv_sel = ilv_lo[0];
      GR_HALF: ilv_sel = ilv_lo[1];
      default: ilv_sel = ilv_lo[2];
    endcase
  end

  always_comb begin
    op_writes = 1'b1;
    result    = '0;
    case (perm_op_e'(op))
      OP_PACK_EVEN: result = f_pack_even(opa, opb);
      OP_ILV_LO:    result = ilv_sel;
      OP_ILV_HI_W:  result = ilv_hi_w;
      OP_BCAST_H:   result = f_bcast_half(opb);
      OP_COPY_LO:   result = {opa[DBL_W-1:0], opb[DBL_W-1:0]};
      OP_COPY_HI:   result = {opb[QUAD_W-1:DBL_W], opa[QUAD_W-1:DBL_W]};
      OP_ROT3:      result = f_rot3(opb);
      default:      op_writes = 1'b0;
    endcase
  end
endmodule

// File: rtl/lperm_out_stage.sv
module lperm_out_stage #(
  parameter int unsigned WIDTH = lperm_pkg::QUAD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             accept,
  input  logic [WIDTH-1:0] next_data,
  output logic             q_valid,
  output logic             q_we,
  output logic [WIDTH-1:0] q_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_we    <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= issue;
      q_we    <= accept;
      if (accept) q_data <= next_data;
    end
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
  parameter int unsigned QWORD_W = lperm_pkg::QUAD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         op,
  input  logic [1:0]         gran,
  input  logic               src_a_zero,
  input  logic               src_b_zero,
  input  logic               dst_zero,
  input  logic [QWORD_W-1:0] src_a,
  input  logic [QWORD_W-1:0] src_b,
  output logic               out_valid,
  output logic               out_we,
  output logic [QWORD_W-1:0] out_data
);
  logic [QWORD_W-1:0] opa_g;
  logic [QWORD_W-1:0] opb_g;
  logic [QWORD_W-1:0] shuf_result;
  logic               op_writes;
  logic               wr_accept;

  lperm_src_gate #(.WIDTH(QWORD_W)) u_gate_a (.raw(src_a), .is_zero_reg(src_a_zero), .gated(opa_g));
  lperm_src_gate #(.WIDTH(QWORD_W)) u_gate_b (.raw(src_b), .is_zero_reg(src_b_zero), .gated(opb_g));

  lperm_shuffle u_shuf (
    .op        (op),
    .gran      (gran),
    .opa       (opa_g),
    .opb       (opb_g),
    .result    (shuf_result),
    .op_writes (op_writes)
  );

  assign wr_accept = in_valid && !dst_zero && op_writes;

  lperm_out_stage #(.WIDTH(QWORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (in_valid),
    .accept    (wr_accept),
    .next_data (shuf_result),
    .q_valid   (out_valid),
    .q_we      (out_we),
    .q_data    (out_data)
  );
endmodule

// File: rtl/lperm_checker.sv
module lperm_checker #(
  parameter int unsigned QWORD_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [2:0]         op,
  input logic               dst_zero,
  input logic               src_b_zero,
  input logic [QWORD_W-1:0] src_b,
  input logic               wr_accept,
  input logic               out_valid,
  input logic               out_we,
  input logic [QWORD_W-1:0] out_data
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_WE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_we |-> out_valid); // R2
  AST_WE_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) wr_accept |=> out_we); // R2
  AST_NOOP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_zero) |=> (!out_we && $stable(out_data))); // R11
  AST_NOOP_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (!out_we && $stable(out_data))); // R12
  AST_ROT_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd6 && !dst_zero && !src_b_zero) |=> out_data[QWORD_W-1 -: 32] == $past(src_b[QWORD_W-1 -: 32])); // R9
  AST_ROT_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd6 && !dst_zero && src_b_zero) |=> out_data == '0); // R10
endmodule

bind lane_permute_unit lperm_checker #(.QWORD_W(QWORD_W)) u_chk (.*);

// File: tb/lane_permute_unit_tb.sv
module lane_permute_unit_tb;
  localparam int W = 128;
  localparam int NV = 9;

  localparam logic [W-1:0] RS = 128'h1F1E1D1C_1B1A1918_17161514_13121110;
  localparam logic [W-1:0] RT = 128'h2F2E2D2C_2B2A2928_27262524_23222120;

  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd1, 3'd1, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  localparam logic [1:0] T_GR [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam string      T_TAG[NV] = '{"R3", "R4", "R4", "R4", "R5", "R6", "R7", "R8", "R9"};
  localparam logic [W-1:0] T_EXP [NV] = '{
    128'h1B1A1918_13121110_2B2A2928_23222120,
    128'h17271626_15251424_13231222_11211020,
    128'h17162726_15142524_13122322_11102120,
    128'h17161514_27262524_13121110_23222120,
    128'h1F1E1D1C_2F2E2D2C_1B1A1918_2B2A2928,
    128'h29282928_29282928_21202120_21202120,
    128'h17161514_13121110_27262524_23222120,
    128'h2F2E2D2C_2B2A2928_1F1E1D1C_1B1A1918,
    128'h2F2E2D2C_23222120_2B2A2928_27262524
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] gran = '0;
  logic src_a_zero = 1'b0, src_b_zero = 1'b0, dst_zero = 1'b0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic out_valid, out_we;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  lane_permute_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .gran(gran),
    .src_a_zero(src_a_zero), .src_b_zero(src_b_zero), .dst_zero(dst_zero),
    .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_we(out_we), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Issue on a falling edge; the result is registered at the next rising edge
  // and sampled at the falling edge after it.
  task automatic issue(input logic [2:0] o, input logic [1:0] g, input logic az,
                       input logic bz, input logic dz);
    @(negedge clk);
    op = o; gran = g; src_a_zero = az; src_b_zero = bz; dst_zero = dz;
    src_a = RS; src_b = RT; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; src_a_zero = 1'b0; src_b_zero = 1'b0; dst_zero = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", {127'd0, out_valid}, '0);
    chk("R1 we", {127'd0, out_we}, '0);
    chk("R1 data", out_data, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_GR[i], 1'b0, 1'b0, 1'b0);
      chk(T_TAG[i], out_data, T_EXP[i]);
      chk("R2 we", {126'd0, out_valid, out_we}, {126'd0, 2'b11});
    end

    @(negedge clk);
    chk("R2 idle", {126'd0, out_valid, out_we}, '0);

    issue(3'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    chk("R4 gran3", out_data, 128'h17161514_27262524_13121110_23222120);

    issue(3'd4, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R10 a zero", out_data, 128'h00000000_00000000_27262524_23222120);
    issue(3'd5, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R10 b zero", out_data, 128'h00000000_00000000_1F1E1D1C_1B1A1918);
    issue(3'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R10 pack a zero", out_data, 128'h00000000_00000000_2B2A2928_23222120);
    issue(3'd6, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R10 rot b zero", out_data, '0);

    issue(3'd6, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R9 setup", out_data, T_EXP[8]);
    issue(3'd4, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R11 hold", out_data, T_EXP[8]);
    chk("R11 we", {126'd0, out_valid, out_we}, {126'd0, 2'b10});

    issue(3'd7, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R12 hold", out_data, T_EXP[8]);
    chk("R12 we", {126'd0, out_valid, out_we}, {126'd0, 2'b10});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule